// File: doc/BRIEF.md
# Segmented Retrigger Capture Controller

This block fills a sample memory in fixed-length segments, one segment for each external trigger. A small circular history buffer is written on every sample strobe and always holds the most recent samples. When a trigger opens a segment, the block moves samples out of that buffer into the main memory. Each segment therefore starts a fixed number of samples before the trigger, which gives the record a negative delay. Samples taken while no segment is open go only into the history buffer and never use main-memory space.

After a set number of segments the memory is full and the block stops writing. A forced-end input can also stop capture early. In either stopped state a host reads the memory back one word per read pulse, starting at address zero. The segment length, the number of segments and the history depth are all parameters.

Top module: `segcap_top`

## Requirements
- R1: While reset is held, and after it is released, mem_en_n is 1, mem_we is 0, mem_full is 0, and seg_cnt, mem_addr, buf_addr and rd_data are all 0.
- R2: Every sample strobe writes adc_data into the history buffer at buf_addr, with buf_we equal to smp_stb. After the strobe buf_addr advances by one and wraps from DEPTH-1 to 0. This holds in every state, including after the memory is full.
- R3: A trigger while no segment is open, the memory is not full and capture has not been ended opens a segment. From the next cycle mem_en_n is 0. Without a trigger no main-memory write occurs.
- R4: While a segment is open, each strobe asserts mem_we in the same cycle and writes main memory at mem_addr. The word written is the history word being overwritten, which is the sample taken DEPTH strobes earlier. mem_addr then increments by one.
- R5: After SEG_LEN writes the segment closes. mem_en_n returns to 1 and seg_cnt increments by one.
- R6: A trigger while a segment is open is ignored. This includes a trigger in the same cycle as the segment's final strobe. The segment still holds exactly SEG_LEN writes, and mem_en_n stays 1 afterwards.
- R7: When seg_cnt reaches SEG_NUM, mem_full becomes 1. After that, triggers and strobes cause no write and mem_addr stays unchanged.
- R8: Read pulses have no effect until the block is full or ended. In that state each read pulse places the word at the read address (starting at 0) on rd_data in the next cycle, and the read address advances by one.
- R9: force_end closes an open segment at once, and the strobe in the same cycle is not written. The partial segment is not counted and mem_full stays 0. Later triggers are ignored, and reading is enabled as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| adc_data | input | 12 | Converted sample |
| trig | input | 1 | Segment trigger |
| force_end | input | 1 | Ends capture early |
| rd_pulse | input | 1 | Host read pulse |
| buf_addr | output | clog2(DEPTH) | History buffer write pointer |
| buf_we | output | 1 | History buffer write strobe |
| mem_addr | output | clog2(SEG_LEN*SEG_NUM)+1 | Main memory write address |
| mem_we | output | 1 | Main memory write strobe (strobe gated by open segment) |
| mem_en_n | output | 1 | Main memory enable, active low, low while a segment is open |
| seg_cnt | output | clog2(SEG_NUM+1) | Completed segments |
| mem_full | output | 1 | All segments captured |
| rd_data | output | 12 | Read-back word |

## Verification
There are two same-cycle collisions. In the first, a segment's final strobe coincides with a new trigger. In the second, a strobe inside an open segment coincides with force_end. The bench drives both as directed cases on top of random strobe spacing. In the first case it checks that the segment still has exactly SEG_LEN writes and that mem_en_n stays high afterwards. In the second it checks that mem_addr does not advance on the colliding strobe and that the read-back data ends at the last write made before the collision.

// File: rtl/segcap_pkg.sv
package segcap_pkg;
  localparam int SMP_W = 12;
  typedef logic [SMP_W-1:0] smp_t;
endpackage

// File: rtl/segcap_ring.sv
module segcap_ring #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  segcap_pkg::smp_t  din,
  output logic [AW-1:0]     ptr,
  output segcap_pkg::smp_t  hist
);
  segcap_pkg::smp_t ring [DEPTH];
  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (stb) ptr_d = (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (stb) ring[ptr_q] <= din;
  end

  // oldest entry: about to be overwritten
  assign hist = ring[ptr_q];
  assign ptr  = ptr_q;
endmodule

// File: rtl/segcap_ctrl.sv
module segcap_ctrl #(
  parameter int SEG_LEN = 64,
  parameter int SEG_NUM = 16,
  localparam int LW = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1,
  localparam int CW = $clog2(SEG_NUM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          trig,
  input  logic          force_end,
  output logic          open,
  output logic          stopped,
  output logic          full,
  output logic [CW-1:0] seg_cnt,
  output logic          wr_en
);
  logic          open_q, open_d, stop_q, stop_d, full_q, full_d;
  logic [LW-1:0] len_q, len_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    open_d = open_q;
    stop_d = stop_q;
    full_d = full_q;
    len_d  = len_q;
    cnt_d  = cnt_q;
    wr_en  = stb & open_q & ~force_end & ~full_q;
    if (force_end && !full_q) begin
      open_d = 1'b0;
      stop_d = 1'b1;
      len_d  = '0;
    end else if (open_q) begin
      if (stb) begin
        if (len_q == LW'(SEG_LEN - 1)) begin
          open_d = 1'b0;
          len_d  = '0;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == CW'(SEG_NUM - 1)) full_d = 1'b1;
        end else begin
          len_d = len_q + 1'b1;
        end
      end
    end else if (trig && !full_q && !stop_q) begin
      open_d = 1'b1;
      len_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      stop_q <= 1'b0;
      full_q <= 1'b0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      stop_q <= stop_d;
      full_q <= full_d;
      len_q  <= len_d;
      cnt_q  <= cnt_d;
    end
  end

  assign open    = open_q;
  assign stopped = stop_q;
  assign full    = full_q;
  assign seg_cnt = cnt_q;
endmodule

// File: rtl/segcap_mem.sv
module segcap_mem #(
  parameter int TOTAL = 1024,
  localparam int AW = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  segcap_pkg::smp_t  wdata,
  input  logic              rd_en,
  output logic [AW:0]       waddr,
  output segcap_pkg::smp_t  rdata
);
  segcap_pkg::smp_t store [TOTAL];
  logic [AW:0]      wa_q, wa_d;
  logic [AW-1:0]    ra_q, ra_d;
  segcap_pkg::smp_t rd_q, rd_d;

  always_comb begin
    wa_d = wa_q;
    ra_d = ra_q;
    rd_d = rd_q;
    if (we) wa_d = wa_q + 1'b1;
    if (rd_en) begin
      rd_d = store[ra_q];
      ra_d = ra_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_q <= '0;
      ra_q <= '0;
      rd_q <= '0;
    end else begin
      wa_q <= wa_d;
      ra_q <= ra_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) store[wa_q[AW-1:0]] <= wdata;
  end

  assign waddr = wa_q;
  assign rdata = rd_q;
endmodule

// File: rtl/segcap_top.sv
module segcap_top #(
  parameter int DEPTH   = 16,
  parameter int SEG_LEN = 64,
  parameter int SEG_NUM = 16,
  localparam int BAW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TOTAL = SEG_LEN * SEG_NUM,
  localparam int MAW   = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int CW    = $clog2(SEG_NUM + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         smp_stb,
  input  logic [segcap_pkg::SMP_W-1:0] adc_data,
  input  logic                         trig,
  input  logic                         force_end,
  input  logic                         rd_pulse,
  output logic [BAW-1:0]               buf_addr,
  output logic                         buf_we,
  output logic [MAW:0]                 mem_addr,
  output logic                         mem_we,
  output logic                         mem_en_n,
  output logic [CW-1:0]                seg_cnt,
  output logic                         mem_full,
  output logic [segcap_pkg::SMP_W-1:0] rd_data
);
  logic [1:0]       rst_sr;
  logic             rst_sync;
  logic             open, stopped, full, wr_en;
  segcap_pkg::smp_t hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_sync = rst_sr[1];

  segcap_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_sync), .stb(smp_stb), .din(adc_data),
    .ptr(buf_addr), .hist(hist)
  );

  segcap_ctrl #(.SEG_LEN(SEG_LEN), .SEG_NUM(SEG_NUM)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .stb(smp_stb), .trig(trig),
    .force_end(force_end), .open(open), .stopped(stopped), .full(full),
    .seg_cnt(seg_cnt), .wr_en(wr_en)
  );

  segcap_mem #(.TOTAL(TOTAL)) u_mem (
    .clk(clk), .rst_n(rst_sync), .we(wr_en), .wdata(hist),
    .rd_en(rd_pulse & (full | stopped)), .waddr(mem_addr), .rdata(rd_data)
  );

  assign buf_we   = smp_stb;
  assign mem_we   = wr_en;
  assign mem_en_n = ~open;
  assign mem_full = full;
endmodule

// File: rtl/segcap_chk.sv
module segcap_chk #(
  parameter int DEPTH   = 16,
  parameter int SEG_NUM = 16,
  parameter int BAW     = 4,
  parameter int MAW     = 10,
  parameter int CW      = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           smp_stb,
  input logic [BAW-1:0] buf_addr,
  input logic [MAW:0]   mem_addr,
  input logic           mem_we,
  input logic           mem_en_n,
  input logic [CW-1:0]  seg_cnt,
  input logic           mem_full
);
  // R2
  ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> buf_addr == (($past(buf_addr) == BAW'(DEPTH - 1)) ? '0 : $past(buf_addr) + 1'b1));
  // R4
  we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (smp_stb && !mem_en_n));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_addr == $past(mem_addr) + 1'b1);
  // R5
  seg_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seg_cnt) |-> $rose(mem_en_n));
  // R7
  full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_full) |-> seg_cnt == CW'(SEG_NUM));
  // R7
  full_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full |=> ($stable(mem_addr) && !mem_we));
endmodule

bind segcap_top segcap_chk #(
  .DEPTH(DEPTH), .SEG_NUM(SEG_NUM), .BAW(BAW), .MAW(MAW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_sync), .smp_stb(smp_stb), .buf_addr(buf_addr),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_en_n(mem_en_n),
  .seg_cnt(seg_cnt), .mem_full(mem_full)
);

// File: tb/segcap_top_tb.sv
module segcap_top_tb;
  localparam int DEPTH = 4, SLEN = 16, SNUM = 4, TOT = SLEN * SNUM;

  logic        clk, rst_n, smp_stb, trig, force_end, rd_pulse;
  logic [11:0] adc_data, rd_data;
  logic [1:0]  buf_addr;
  logic [6:0]  mem_addr;
  logic        buf_we, mem_we, mem_en_n, mem_full;
  logic [2:0]  seg_cnt;

  int checks = 0, errors = 0, n = 0, wr_cnt = 0;
  logic [11:0] hist [0:1023];
  logic [11:0] exp_mem [0:TOT-1];
  bit done = 0;

  segcap_top #(.DEPTH(DEPTH), .SEG_LEN(SLEN), .SEG_NUM(SNUM)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .adc_data(adc_data),
    .trig(trig), .force_end(force_end), .rd_pulse(rd_pulse),
    .buf_addr(buf_addr), .buf_we(buf_we), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_en_n(mem_en_n), .seg_cnt(seg_cnt), .mem_full(mem_full), .rd_data(rd_data)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [11:0] d, input logic t, input logic f);
    @(negedge clk);
    smp_stb = 1; adc_data = d; trig = t; force_end = f;
    #1;
    if (mem_we) wr_cnt++;
    if (buf_we !== 1'b1) chk("R2 buf_we", buf_we, 1);
    hist[n] = d; n++;
    @(negedge clk);
    smp_stb = 0; trig = 0; force_end = 0;
    repeat ($urandom_range(2, 0)) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; smp_stb = 0; trig = 0; force_end = 0; rd_pulse = 0; adc_data = 0;
    n = 0; wr_cnt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_one(input int idx, input string req);
    @(negedge clk); rd_pulse = 1;
    @(negedge clk); rd_pulse = 0;
    chk(req, rd_data, exp_mem[idx]);
  endtask

  // capture one segment; 'late' puts a trigger on the final strobe
  task automatic segment(input int s, input bit late);
    pulse_trig();
    chk("R3 open after trigger", mem_en_n, 0);
    for (int j = 0; j < SLEN; j++) begin
      exp_mem[s*SLEN + j] = hist[n - DEPTH];
      if (j == 5) pulse_trig();  // R6 retrigger while open
      strobe(12'($urandom), (late && j == SLEN - 1), 0);
    end
    chk("R5 closed", mem_en_n, 1);
    chk("R5 seg_cnt", seg_cnt, s + 1);
    chk("R4/R6 write count", wr_cnt, (s + 1) * SLEN);
    chk("R4 mem_addr", mem_addr, (s + 1) * SLEN);
    repeat (3) @(negedge clk);
    chk("R6 still closed", mem_en_n, 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    chk("R1 mem_en_n", mem_en_n, 1);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 mem_full", mem_full, 0);
    chk("R1 seg_cnt", seg_cnt, 0);
    chk("R1 mem_addr", mem_addr, 0);
    chk("R1 buf_addr", buf_addr, 0);
    chk("R1 rd_data", rd_data, 0);

    // R8 read pulse before full is ignored
    @(negedge clk); rd_pulse = 1;
    @(negedge clk); rd_pulse = 0;
    chk("R8 early read ignored", rd_data, 0);

    for (int i = 0; i < 6; i++) strobe(12'($urandom), 0, 0);
    chk("R2 buf_addr wrap", buf_addr, n % DEPTH);
    chk("R3 no write without trigger", wr_cnt, 0);

    for (int s = 0; s < SNUM; s++) begin
      segment(s, s == 1);
      for (int k = 0; k < int'($urandom_range(5, 0)); k++) strobe(12'($urandom), 0, 0);
      chk("R3 idle no write", wr_cnt, (s + 1) * SLEN);
    end
    chk("R7 full", mem_full, 1);
    chk("R7 seg_cnt", seg_cnt, SNUM);

    pulse_trig();
    chk("R7 trigger ignored", mem_en_n, 1);
    for (int i = 0; i < 5; i++) strobe(12'($urandom), 0, 0);
    chk("R7 no write", wr_cnt, TOT);
    chk("R7 addr frozen", mem_addr, TOT);
    chk("R2 buf_addr after full", buf_addr, n % DEPTH);

    for (int i = 0; i < TOT; i++) read_one(i, "R8 readback");

    // force-end phase
    do_reset();
    for (int i = 0; i < 4; i++) strobe(12'($urandom), 0, 0);
    pulse_trig();
    for (int j = 0; j < 5; j++) begin
      exp_mem[j] = hist[n - DEPTH];
      strobe(12'($urandom), 0, 0);
    end
    strobe(12'($urandom), 0, 1);  // collides with force_end
    chk("R9 closed", mem_en_n, 1);
    chk("R9 addr", mem_addr, 5);
    chk("R9 seg_cnt", seg_cnt, 0);
    chk("R9 not full", mem_full, 0);
    pulse_trig();
    strobe(12'($urandom), 0, 0);
    chk("R9 trigger ignored", mem_en_n, 1);
    chk("R9 no write", wr_cnt, 5);
    for (int i = 0; i < 5; i++) read_one(i, "R9 readback");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule